// File: doc/BRIEF.md
# Strided Lane Shuffle Network

This block permutes one wide vector by lanes, one cycle after the vector arrives. The vector is split into equal lanes of 1, 2, 4 or 8 bytes, chosen by a lane-width select. A shuffle select then picks one of four lane orders. One is the identity. The other three interleave the lane sequence with a group factor of 2, 4 or 8.

With group factor g and N lanes, output lane j takes input lane (j / g) + (j mod g) * (N / g). Lanes are whole units, so the bytes inside a lane keep their order. The permuted vector is captured in an output register together with a valid flag. The selects are sampled in the same cycle as the data, so every beat may use its own lane width and shuffle.

The unit sits between operand fetch and the arithmetic that uses the operand. It is purely a routing stage: it does no arithmetic and has no state beyond the output register.

Top module: `ls_shuffle`

## Requirements
- R1: With `in_shuf` = 0, the output vector equals the input vector at every lane width.
- R2: With `in_shuf` = 1 (group factor 2), output lane j takes input lane j/2 + (j mod 2)*N/2. For 8-byte lanes in a 64-byte vector, the output order is input lanes 0,4,1,5,2,6,3,7.
- R3: With `in_shuf` = 2 (group factor 4), output lane j takes input lane j/4 + (j mod 4)*N/4. For 4-byte lanes in a 64-byte vector, the output order is 0,4,8,12,1,5,9,13,2,6,10,14,3,7,11,15.
- R4: With `in_shuf` = 3 (group factor 8), output lane j takes input lane j/8 + (j mod 8)*N/8, so input lane 1 lands at output lane 8. When N is 8, this shuffle equals the identity.
- R5: `in_width` codes 0, 1, 2 and 3 select lanes of 1, 2, 4 and 8 bytes. Lane j occupies bytes j*LB to j*LB+LB-1, with byte 0 in bits 7:0. Bytes keep their order inside a moved lane.
- R6: `out_valid` is high in the cycle after a cycle with `in_valid` high. The `out_vec` value shown then is the input of that beat, permuted with the selects sampled in the same cycle. Back-to-back beats are accepted every cycle.
- R7: In the cycle after a cycle with `in_valid` low, `out_valid` is low and `out_vec` keeps its previous value, whatever the data and select inputs do.
- R8: A cycle with `rst` high clears `out_valid` and `out_vec` to zero at that clock edge, even if `in_valid` is high.
- R9: The first lane and the last lane never move under any shuffle or lane width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat present |
| in_vec | input | VEC_BYTES*8 | Vector to permute, byte 0 in bits 7:0 |
| in_shuf | input | 2 | Shuffle select: 0 identity, 1/2/3 group factor 2/4/8 |
| in_width | input | 2 | Lane width select: 0/1/2/3 for 1/2/4/8-byte lanes |
| out_valid | output | 1 | Registered result valid |
| out_vec | output | VEC_BYTES*8 | Registered permuted vector |

## Verification
The bench builds two instances. One uses the default 64-byte vector, where the lane counts are 64, 32, 16 and 8 and the group-factor-8 shuffle collapses to the identity at 8-byte lanes. The other uses a 128-byte vector, where 8-byte lanes give 16 lanes, so the group-factor-8 shuffle really moves data at that width and the byte width reaches 128 lanes. Every input byte carries a distinct value, so any misrouted byte, any reordering inside a lane, or a select taken from the wrong cycle shows up in the compared vector.

// File: rtl/ls_pkg.sv
package ls_pkg;

  typedef enum logic [1:0] {
    SHUF_ID = 2'd0,
    SHUF_G2 = 2'd1,
    SHUF_G4 = 2'd2,
    SHUF_G8 = 2'd3
  } shuf_e;

  typedef enum logic [1:0] {
    LW_B1 = 2'd0,
    LW_B2 = 2'd1,
    LW_B4 = 2'd2,
    LW_B8 = 2'd3
  } lane_w_e;

  // Source lane for output lane j, group factor 2**lg_g, lane count 2**lg_n.
  function automatic int unsigned src_lane(int unsigned j, int unsigned lg_g,
                                           int unsigned lg_n);
    int unsigned g_mask;
    g_mask = (32'd1 << lg_g) - 32'd1;
    return (j >> lg_g) + ((j & g_mask) << (lg_n - lg_g));
  endfunction

endpackage

// File: rtl/ls_width_net.sv
// Four constant lane permutations for one lane width, picked by shuffle select.
module ls_width_net #(
  parameter int VEC_BYTES = 64,
  parameter int LG_LB     = 0
) (
  input  logic [VEC_BYTES*8-1:0] vec_i,
  input  logic [1:0]             shuf_i,
  output logic [VEC_BYTES*8-1:0] vec_o
);
  localparam int VEC_BITS = VEC_BYTES * 8;
  localparam int LB       = 1 << LG_LB;
  localparam int N_LANES  = VEC_BYTES / LB;
  localparam int LG_N     = $clog2(N_LANES);
  localparam int N_SHUF   = 4;

  logic [N_SHUF-1:0][VEC_BITS-1:0] perm;

  for (genvar s = 0; s < N_SHUF; s++) begin : g_shuf
    for (genvar b = 0; b < VEC_BYTES; b++) begin : g_byte
      localparam int LANE = b / LB;
      localparam int OFS  = b % LB;
      localparam int SRC  = int'(ls_pkg::src_lane(LANE, s, LG_N)) * LB + OFS;
      assign perm[s][b*8 +: 8] = vec_i[SRC*8 +: 8];
    end
  end

  always_comb vec_o = perm[shuf_i];

endmodule

// File: rtl/ls_width_sel.sv
// One permutation network per lane width, followed by a width multiplexer.
module ls_width_sel #(
  parameter int VEC_BYTES = 64
) (
  input  logic [VEC_BYTES*8-1:0] vec_i,
  input  logic [1:0]             shuf_i,
  input  logic [1:0]             width_i,
  output logic [VEC_BYTES*8-1:0] vec_o
);
  localparam int VEC_BITS = VEC_BYTES * 8;
  localparam int N_WIDTH  = 4;

  logic [VEC_BITS-1:0] by_w [N_WIDTH];

  for (genvar w = 0; w < N_WIDTH; w++) begin : g_width
    ls_width_net #(
      .VEC_BYTES (VEC_BYTES),
      .LG_LB     (w)
    ) u_net (
      .vec_i  (vec_i),
      .shuf_i (shuf_i),
      .vec_o  (by_w[w])
    );
  end

  always_comb vec_o = by_w[width_i];

endmodule

// File: rtl/ls_out_stage.sv
// Result register: valid follows the input beat, data holds between beats.
module ls_out_stage #(
  parameter int VEC_BITS = 512
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid_i,
  input  logic [VEC_BITS-1:0] data_i,
  output logic                valid_o,
  output logic [VEC_BITS-1:0] data_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= data_i;
    end
  end

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (!valid_o && $stable(data_o)));

  // R8
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!valid_o && data_o == '0));

endmodule

// File: rtl/ls_shuffle.sv
module ls_shuffle #(
  parameter int VEC_BYTES = 64
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [VEC_BYTES*8-1:0] in_vec,
  input  logic [1:0]             in_shuf,
  input  logic [1:0]             in_width,
  output logic                   out_valid,
  output logic [VEC_BYTES*8-1:0] out_vec
);
  localparam int VEC_BITS = VEC_BYTES * 8;
  localparam int TOP_BYTE = VEC_BITS - 8;

  logic [VEC_BITS-1:0] perm_vec;

  ls_width_sel #(
    .VEC_BYTES (VEC_BYTES)
  ) u_sel (
    .vec_i   (in_vec),
    .shuf_i  (in_shuf),
    .width_i (in_width),
    .vec_o   (perm_vec)
  );

  ls_out_stage #(
    .VEC_BITS (VEC_BITS)
  ) u_out (
    .clk     (clk),
    .rst     (rst),
    .valid_i (in_valid),
    .data_i  (perm_vec),
    .valid_o (out_valid),
    .data_o  (out_vec)
  );

  // R1
  identity_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_shuf == ls_pkg::SHUF_ID) |=> (out_vec == $past(in_vec)));

  // R4
  g8_narrow_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_shuf == ls_pkg::SHUF_G8 && in_width == ls_pkg::LW_B8
     && VEC_BYTES == 64) |=> (out_vec == $past(in_vec)));

  // R6
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R9
  ends_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_vec[7:0] == $past(in_vec[7:0])
                  && out_vec[TOP_BYTE +: 8] == $past(in_vec[TOP_BYTE +: 8])));

endmodule

// File: tb/ls_shuffle_bench.sv
`timescale 1ns/1ps
module ls_shuffle_bench;
  localparam int NB_A = 64;
  localparam int NB_B = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic              a_valid = 1'b0;
  logic [NB_A*8-1:0] a_vec   = '0;
  logic [1:0]        a_shuf  = 2'd0;
  logic [1:0]        a_width = 2'd0;
  logic              a_ovalid;
  logic [NB_A*8-1:0] a_out;

  logic              b_valid = 1'b0;
  logic [NB_B*8-1:0] b_vec   = '0;
  logic [1:0]        b_shuf  = 2'd0;
  logic [1:0]        b_width = 2'd0;
  logic              b_ovalid;
  logic [NB_B*8-1:0] b_out;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 1'b0;

  ls_shuffle #(.VEC_BYTES(NB_A)) u_ls_shuffle (
    .clk(clk), .rst(rst), .in_valid(a_valid), .in_vec(a_vec),
    .in_shuf(a_shuf), .in_width(a_width), .out_valid(a_ovalid), .out_vec(a_out));

  ls_shuffle #(.VEC_BYTES(NB_B)) u_ls_shuffle_wide (
    .clk(clk), .rst(rst), .in_valid(b_valid), .in_vec(b_vec),
    .in_shuf(b_shuf), .in_width(b_width), .out_valid(b_ovalid), .out_vec(b_out));

  // Distinct value in every byte position.
  function automatic logic [1023:0] pat(int seed, int nbytes);
    logic [1023:0] r;
    r = '0;
    for (int b = 0; b < nbytes; b++) r[b*8 +: 8] = 8'((b * 7 + seed) & 255);
    return r;
  endfunction

  // Every byte of lane i holds the value i.
  function automatic logic [511:0] lane_fill(int width);
    logic [511:0] r;
    r = '0;
    for (int b = 0; b < NB_A; b++) r[b*8 +: 8] = 8'(b >> width);
    return r;
  endfunction

  function automatic logic [1023:0] model(logic [1023:0] v, int shuf, int width, int nbytes);
    logic [1023:0] r;
    int lb, n, g;
    r  = '0;
    lb = 1 << width;
    n  = nbytes / lb;
    g  = 1 << shuf;
    for (int b = 0; b < nbytes; b++) begin
      int j, k, src;
      j   = b / lb;
      k   = b % lb;
      src = (j / g) + (j % g) * (n / g);
      r[b*8 +: 8] = v[(src * lb + k)*8 +: 8];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [1023:0] act, input logic [1023:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic beat_a(input logic [511:0] v, input int s, input int w);
    @(negedge clk);
    a_vec = v; a_shuf = 2'(s); a_width = 2'(w); a_valid = 1'b1;
    @(negedge clk);
    a_valid = 1'b0;
  endtask

  task automatic beat_b(input logic [1023:0] v, input int s, input int w);
    @(negedge clk);
    b_vec = v; b_shuf = 2'(s); b_width = 2'(w); b_valid = 1'b1;
    @(negedge clk);
    b_valid = 1'b0;
  endtask

  task automatic t_reset();
    // R8: reset with a valid beat present
    rst = 1'b1;
    a_vec = pat(3, NB_A); a_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 reset valid", 1024'(a_ovalid), 1024'(0));
    check("R8 reset data", 1024'(a_out), 1024'(0));
    a_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_identity();
    for (int w = 0; w < 4; w++) begin
      logic [511:0] v;
      v = pat(11 + w, NB_A);
      beat_a(v, 0, w);
      check("R1 identity", 1024'(a_out), 1024'(v));
      check("R6 valid after beat", 1024'(a_ovalid), 1024'(1));
    end
  endtask

  task automatic t_g2();
    int ord [8] = '{0, 4, 1, 5, 2, 6, 3, 7};
    logic [511:0] exp;
    exp = '0;
    for (int j = 0; j < 8; j++) exp[j*64 +: 64] = {8{8'(ord[j])}};
    beat_a(lane_fill(3), 1, 3);
    check("R2 order 8 lanes", 1024'(a_out), 1024'(exp));
    for (int w = 0; w < 3; w++) begin
      logic [511:0] v;
      v = pat(20 + w, NB_A);
      beat_a(v, 1, w);
      check("R2 group 2", 1024'(a_out), model(1024'(v), 1, w, NB_A));
    end
  endtask

  task automatic t_g4();
    logic [511:0] exp;
    exp = '0;
    for (int j = 0; j < 16; j++) exp[j*32 +: 32] = {4{8'((j / 4) + (j % 4) * 4)}};
    beat_a(lane_fill(2), 2, 2);
    check("R3 order 16 lanes", 1024'(a_out), 1024'(exp));
    for (int w = 0; w < 4; w++) begin
      logic [511:0] v;
      v = pat(40 + w, NB_A);
      beat_a(v, 2, w);
      check("R3 group 4", 1024'(a_out), model(1024'(v), 2, w, NB_A));
    end
  endtask

  task automatic t_g8();
    logic [511:0] v;
    v = pat(60, NB_A);
    beat_a(v, 3, 3);
    check("R4 identity at 8 lanes", 1024'(a_out), 1024'(v));
    beat_a(v, 3, 2);
    check("R4 lane1 to lane8", 1024'(a_out[8*32 +: 32]), 1024'(v[1*32 +: 32]));
    for (int w = 0; w < 3; w++) begin
      beat_a(v, 3, w);
      check("R4 group 8", 1024'(a_out), model(1024'(v), 3, w, NB_A));
    end
  endtask

  task automatic t_width();
    logic [511:0] v;
    v = pat(77, NB_A);
    for (int w = 0; w < 4; w++) begin
      beat_a(v, 1, w);
      check("R5 width code", 1024'(a_out), model(1024'(v), 1, w, NB_A));
    end
    beat_a(v, 1, 3);
    // 8-byte lanes, group 2: output lane 1 is input lane 4, bytes in order
    check("R5 byte order in lane", 1024'(a_out[64 +: 64]), 1024'(v[4*64 +: 64]));
  endtask

  task automatic t_stream();
    logic [511:0] pv;
    int ps, pw;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check("R6 back-to-back valid", 1024'(a_ovalid), 1024'(1));
        check("R6 back-to-back data", 1024'(a_out), model(1024'(pv), ps, pw, NB_A));
      end
      pv = pat(90 + i, NB_A); ps = i % 4; pw = (i * 3) % 4;
      a_vec = pv; a_shuf = 2'(ps); a_width = 2'(pw); a_valid = 1'b1;
    end
    @(negedge clk);
    a_valid = 1'b0;
    check("R6 last beat data", 1024'(a_out), model(1024'(pv), ps, pw, NB_A));
  endtask

  task automatic t_hold();
    logic [511:0] v;
    v = pat(120, NB_A);
    beat_a(v, 2, 1);
    for (int i = 0; i < 3; i++) begin
      a_vec = pat(130 + i, NB_A); a_shuf = 2'(i); a_width = 2'(3 - i);
      @(negedge clk);
      check("R7 hold data", 1024'(a_out), model(1024'(v), 2, 1, NB_A));
      check("R7 valid low", 1024'(a_ovalid), 1024'(0));
    end
  endtask

  task automatic t_ends();
    logic [511:0] v;
    v = pat(150, NB_A);
    for (int s = 1; s < 4; s++) begin
      for (int w = 0; w < 4; w++) begin
        int lb;
        lb = 8 << w;
        beat_a(v, s, w);
        check("R9 first lane", 1024'(a_out[0 +: 8] ), 1024'(v[0 +: 8]));
        check("R9 last lane", 1024'(a_out[511 -: 64] >> (64 - lb)),
              1024'(v[511 -: 64] >> (64 - lb)));
      end
    end
  endtask

  task automatic t_wide();
    logic [1023:0] v;
    v = pat(5, NB_B);
    for (int s = 0; s < 4; s++) begin
      for (int w = 0; w < 4; w++) begin
        beat_b(v, s, w);
        check("R5 wide vector", b_out, model(v, s, w, NB_B));
      end
    end
    beat_b(v, 3, 3);
    // 16 lanes of 8 bytes: lane 1 lands at lane 8
    check("R4 wide lane1 to lane8", 1024'(b_out[8*64 +: 64]), 1024'(v[64 +: 64]));
  endtask

  task automatic t_reset_mid();
    beat_a(pat(200, NB_A), 1, 0);
    @(negedge clk);
    rst = 1'b1; a_valid = 1'b1;
    @(negedge clk);
    check("R8 mid-run clear data", 1024'(a_out), 1024'(0));
    check("R8 mid-run clear valid", 1024'(a_ovalid), 1024'(0));
    rst = 1'b0; a_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  endtask

  initial begin
    t_reset();
    t_identity();
    t_g2();
    t_g4();
    t_g8();
    t_width();
    t_stream();
    t_hold();
    t_ends();
    t_wide();
    t_reset_mid();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL R6 watchdog actual=timeout expected=completion");
      summary();
    end
  end

endmodule